// File: doc/BRIEF.md
# Passive-Parallel Configuration Sequencer

This block steps a passive-parallel FPGA configuration handshake in a fixed order, one state per step. A start pulse launches it. It first checks the mode-select pins. It then waits until the external nCONFIG and nSTATUS lines are released. Next it takes over the configuration lines and pulses nCONFIG. It confirms that nSTATUS and CONF_DONE respond as expected, then opens the data and clock path so that an outside source can stream the bitstream.

After the stream ends, the block waits for CONF_DONE and then for user mode. It then hands the lines back and makes a last check of the status pins. The streaming itself happens outside the block. The data source only reports the end of the stream.

Every wait is bounded by a cycle count that is set on an input. A failure leaves the sequencer in an error state with a 4-bit code that names the step that failed, and the control lines are returned to their released values. A clean run ends in a done state with code 0. Either end state holds until the next start.

Top module: `cfgseq_top`

## Requirements
- R1: After reset the outputs read nCe=1, nConfig=1, prRequest=0, nStatusOe=0, confDoneOe=0, all four active-low override enables=1, dataEn=0, clkEn=0, busy=0, done=0 and errCode=0.
- R2: If any modeSel bit other than bit 0 is set, the run ends with errCode=1. modeSel values 0 and 1 pass this check.
- R3: Each wait state has a timeout. The wait fails once its condition has been false on timeoutLimit+1 consecutive cycles of that state, and a met condition wins over the timeout on the same cycle. For the first wait (pinNConfig and pinNStatus both low), a timeout shows errCode=2 exactly timeoutLimit+2 clock edges after the edge that samples start.
- R4: The takeover happens in three steps. First the initial drive values are applied: nCe=1, prRequest=0, enables 0, nConfig=1, both output enables 0. Next the config and nCONFIG overrides are set to 0, while the nSTATUS and CONF_DONE overrides are set to 1. Then nCe is driven 0. A second wait for both pins low follows, with timeout code 3.
- R5: nConfig is driven low only while nConfigOvrN=0 and nCe=0. The block waits for pinNStatus low (timeout code 4), then drives nConfig high and waits for pinNStatus high (timeout code 5).
- R6: After the pulse, pinConfDone must be 0 and pinConfDoneOe must be 1. Otherwise the run ends with errCode=6.
- R7: dataEn and clkEn are 1 only while streaming. During that time nCe=0, nConfig=1, both taken-over overrides are 0 and the other two overrides are 1. streamEnd ends streaming, and a stream with no streamEnd times out with code 7.
- R8: During the CONF_DONE wait, pinConfDone=1 moves on. Otherwise pinNStatus=0 ends the run at the next edge with code 9, ahead of the timeout (code 8).
- R9: The user-mode wait has timeout code 10. Once user mode is reached, the block clears both enables, sets the config and nCONFIG overrides to 1, and drives nCe=1.
- R10: The final check needs pinUserMode, pinConfDone and pinNStatus all high. It otherwise gives code 11. On success done=1 and errCode=0.
- R11: On any error the outputs take the released values (nCe=1, nConfig=1, enables 0, config/nCONFIG overrides 1), busy=0, and errCode holds until the next start.
- R12: start is ignored while busy=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a run when the sequencer is idle, done or in error |
| timeoutLimit | input | TW | Cycle bound used by every wait state |
| modeSel | input | MW | Mode-select pin status |
| pinNConfig | input | 1 | External nCONFIG status (0 = released) |
| pinNStatus | input | 1 | External nSTATUS status |
| pinConfDone | input | 1 | CONF_DONE status |
| pinConfDoneOe | input | 1 | CONF_DONE output-enable status |
| pinUserMode | input | 1 | Device-in-user-mode status |
| streamEnd | input | 1 | Data source reports the end of the bitstream |
| nCe | output | 1 | Chip enable, active low |
| nConfig | output | 1 | nCONFIG drive value |
| prRequest | output | 1 | Partial-reconfiguration request (held 0) |
| nStatusOe | output | 1 | nSTATUS output enable (held 0) |
| confDoneOe | output | 1 | CONF_DONE output enable (held 0) |
| cfgOvrN | output | 1 | Configuration-line override enable, active low |
| nConfigOvrN | output | 1 | nCONFIG override enable, active low |
| nStatusOvrN | output | 1 | nSTATUS override enable, active low |
| confDoneOvrN | output | 1 | CONF_DONE override enable, active low |
| dataEn | output | 1 | Data path enable |
| clkEn | output | 1 | Configuration clock enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run finished cleanly |
| errCode | output | 4 | Failing step of the last run, 0 if none |

## Verification
The assertions assume that the pin inputs change only between clock edges and that start is a pulse. They also assume that after a run begins, the status pins behave like a single device that answers the control outputs.

The stimulus is a reactive pin model inside the bench. It releases the lines after a random hold, answers the nCONFIG pulse, raises CONF_DONE and user mode after random delays, and ends the stream. Every delay stays below half of a random timeoutLimit, so a run fails only where a fault is injected on purpose. Each fault makes exactly one step fail.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  typedef enum logic [4:0] {
    S_IDLE, S_CHKMODE, S_WAITREL, S_DRVINIT, S_OVRON, S_CELOW, S_WAITREL2,
    S_PULSELO, S_WAITNSLO, S_PULSEHI, S_WAITNSHI, S_CHKCD, S_STREAM,
    S_WAITCD, S_WAITUM, S_RELEASE, S_FINAL, S_DONE, S_ERR
  } seqState_t;

  typedef enum logic [3:0] {
    E_NONE    = 4'd0,
    E_MODE    = 4'd1,
    E_REL     = 4'd2,
    E_REL2    = 4'd3,
    E_NSLOW   = 4'd4,
    E_NSHIGH  = 4'd5,
    E_POSTCHK = 4'd6,
    E_STREAM  = 4'd7,
    E_CDTMO   = 4'd8,
    E_CDNS    = 4'd9,
    E_UMTMO   = 4'd10,
    E_FINAL   = 4'd11
  } errCode_t;

  typedef struct packed {
    logic     tmrClr;
    logic     drvInit;
    logic     ovrOn;
    logic     ceLow;
    logic     cfgLow;
    logic     cfgHigh;
    logic     streamOn;
    logic     streamOff;
    logic     releaseAll;
    logic     errLoad;
    logic     errClr;
    errCode_t errVal;
  } seqStrobe_t;

endpackage

// File: rtl/cfgseq_dp.sv
module cfgseq_dp
  import cfgseq_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    stb,
  input  logic [TW-1:0] timeoutLimit,
  output logic          tmo,
  output logic          nCe,
  output logic          nConfig,
  output logic          prRequest,
  output logic          nStatusOe,
  output logic          confDoneOe,
  output logic          cfgOvrN,
  output logic          nConfigOvrN,
  output logic          nStatusOvrN,
  output logic          confDoneOvrN,
  output logic          dataEn,
  output logic          clkEn,
  output logic [3:0]    errCode
);

  localparam logic [TW-1:0] CNT_MAX = {TW{1'b1}};

  logic [TW-1:0] cnt;

  // Wait-state cycle counter: cleared on every state change, saturating.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (stb.tmrClr)      cnt <= '0;
    else if (cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  assign tmo = (cnt >= timeoutLimit);

  // Chip enable and nCONFIG drive.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nCe     <= 1'b1;
      nConfig <= 1'b1;
    end else if (stb.releaseAll || stb.drvInit) begin
      nCe     <= 1'b1;
      nConfig <= 1'b1;
    end else begin
      if (stb.ceLow)   nCe     <= 1'b0;
      if (stb.cfgLow)  nConfig <= 1'b0;
      if (stb.cfgHigh) nConfig <= 1'b1;
    end
  end

  // Fixed drive values applied at takeover.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prRequest  <= 1'b0;
      nStatusOe  <= 1'b0;
      confDoneOe <= 1'b0;
    end else if (stb.drvInit) begin
      prRequest  <= 1'b0;
      nStatusOe  <= 1'b0;
      confDoneOe <= 1'b0;
    end
  end

  // Override enables (active low).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgOvrN      <= 1'b1;
      nConfigOvrN  <= 1'b1;
      nStatusOvrN  <= 1'b1;
      confDoneOvrN <= 1'b1;
    end else if (stb.releaseAll) begin
      cfgOvrN      <= 1'b1;
      nConfigOvrN  <= 1'b1;
    end else if (stb.ovrOn) begin
      cfgOvrN      <= 1'b0;
      nConfigOvrN  <= 1'b0;
      nStatusOvrN  <= 1'b1;
      confDoneOvrN <= 1'b1;
    end
  end

  // Data and clock enables.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataEn <= 1'b0;
      clkEn  <= 1'b0;
    end else if (stb.releaseAll || stb.streamOff || stb.drvInit) begin
      dataEn <= 1'b0;
      clkEn  <= 1'b0;
    end else if (stb.streamOn) begin
      dataEn <= 1'b1;
      clkEn  <= 1'b1;
    end
  end

  // Error code register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            errCode <= E_NONE;
    else if (stb.errLoad) errCode <= stb.errVal;
    else if (stb.errClr)  errCode <= E_NONE;
  end

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.errLoad && !stb.errClr) |=> $stable(errCode));

  // R3
  tmr_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.tmrClr |=> !tmo || (timeoutLimit == '0));

endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
#(
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [MW-1:0] modeSel,
  input  logic          pinNConfig,
  input  logic          pinNStatus,
  input  logic          pinConfDone,
  input  logic          pinConfDoneOe,
  input  logic          pinUserMode,
  input  logic          streamEnd,
  input  logic          tmo,
  output seqStrobe_t    stb,
  output logic          busy,
  output logic          done
);

  seqState_t state, nxt;
  logic      linesFree;

  assign linesFree = !pinNConfig && !pinNStatus;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt = state;
    stb = '0;
    stb.errVal = E_NONE;
    unique case (state)
      S_IDLE, S_DONE, S_ERR: begin
        if (start) begin
          nxt        = S_CHKMODE;
          stb.errClr = 1'b1;
        end
      end
      S_CHKMODE: begin
        if (|modeSel[MW-1:1]) begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_MODE; stb.releaseAll = 1'b1;
        end else begin
          nxt = S_WAITREL;
        end
      end
      S_WAITREL: begin
        if (linesFree) nxt = S_DRVINIT;
        else if (tmo) begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_REL; stb.releaseAll = 1'b1;
        end
      end
      S_DRVINIT: begin
        stb.drvInit = 1'b1;
        nxt = S_OVRON;
      end
      S_OVRON: begin
        stb.ovrOn = 1'b1;
        nxt = S_CELOW;
      end
      S_CELOW: begin
        stb.ceLow = 1'b1;
        nxt = S_WAITREL2;
      end
      S_WAITREL2: begin
        if (linesFree) nxt = S_PULSELO;
        else if (tmo) begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_REL2; stb.releaseAll = 1'b1;
        end
      end
      S_PULSELO: begin
        stb.cfgLow = 1'b1;
        nxt = S_WAITNSLO;
      end
      S_WAITNSLO: begin
        if (!pinNStatus) nxt = S_PULSEHI;
        else if (tmo) begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_NSLOW; stb.releaseAll = 1'b1;
        end
      end
      S_PULSEHI: begin
        stb.cfgHigh = 1'b1;
        nxt = S_WAITNSHI;
      end
      S_WAITNSHI: begin
        if (pinNStatus) nxt = S_CHKCD;
        else if (tmo) begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_NSHIGH; stb.releaseAll = 1'b1;
        end
      end
      S_CHKCD: begin
        if (!pinConfDone && pinConfDoneOe) begin
          nxt = S_STREAM; stb.streamOn = 1'b1;
        end else begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_POSTCHK; stb.releaseAll = 1'b1;
        end
      end
      S_STREAM: begin
        if (streamEnd) begin
          nxt = S_WAITCD; stb.streamOff = 1'b1;
        end else if (tmo) begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_STREAM; stb.releaseAll = 1'b1;
        end
      end
      S_WAITCD: begin
        if (pinConfDone) nxt = S_WAITUM;
        else if (!pinNStatus) begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_CDNS; stb.releaseAll = 1'b1;
        end else if (tmo) begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_CDTMO; stb.releaseAll = 1'b1;
        end
      end
      S_WAITUM: begin
        if (pinUserMode) nxt = S_RELEASE;
        else if (tmo) begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_UMTMO; stb.releaseAll = 1'b1;
        end
      end
      S_RELEASE: begin
        stb.releaseAll = 1'b1;
        nxt = S_FINAL;
      end
      S_FINAL: begin
        if (pinUserMode && pinConfDone && pinNStatus) nxt = S_DONE;
        else begin
          nxt = S_ERR; stb.errLoad = 1'b1; stb.errVal = E_FINAL; stb.releaseAll = 1'b1;
        end
      end
      default: nxt = S_IDLE;
    endcase
    stb.tmrClr = (nxt != state);
  end

  assign busy = !(state inside {S_IDLE, S_DONE, S_ERR});
  assign done = (state == S_DONE);

  // R8
  cd_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAITCD && !pinConfDone && !pinNStatus) |=> (state == S_ERR));

  // R8
  cd_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAITCD && pinConfDone) |=> (state == S_WAITUM));

  // R12
  start_ign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != S_CHKMODE) |=> (state != S_CHKMODE));

  // R2
  mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CHKMODE && modeSel[MW-1:1] != '0) |=> (state == S_ERR));

endmodule

// File: rtl/cfgseq_top.sv
module cfgseq_top
  import cfgseq_pkg::*;
#(
  parameter int TW = 16,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [TW-1:0] timeoutLimit,
  input  logic [MW-1:0] modeSel,
  input  logic          pinNConfig,
  input  logic          pinNStatus,
  input  logic          pinConfDone,
  input  logic          pinConfDoneOe,
  input  logic          pinUserMode,
  input  logic          streamEnd,
  output logic          nCe,
  output logic          nConfig,
  output logic          prRequest,
  output logic          nStatusOe,
  output logic          confDoneOe,
  output logic          cfgOvrN,
  output logic          nConfigOvrN,
  output logic          nStatusOvrN,
  output logic          confDoneOvrN,
  output logic          dataEn,
  output logic          clkEn,
  output logic          busy,
  output logic          done,
  output logic [3:0]    errCode
);

  seqStrobe_t stb;
  logic       tmo;

  cfgseq_ctrl #(.MW(MW)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeSel(modeSel),
    .pinNConfig(pinNConfig), .pinNStatus(pinNStatus), .pinConfDone(pinConfDone),
    .pinConfDoneOe(pinConfDoneOe), .pinUserMode(pinUserMode), .streamEnd(streamEnd),
    .tmo(tmo), .stb(stb), .busy(busy), .done(done)
  );

  cfgseq_dp #(.TW(TW)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .timeoutLimit(timeoutLimit), .tmo(tmo),
    .nCe(nCe), .nConfig(nConfig), .prRequest(prRequest), .nStatusOe(nStatusOe),
    .confDoneOe(confDoneOe), .cfgOvrN(cfgOvrN), .nConfigOvrN(nConfigOvrN),
    .nStatusOvrN(nStatusOvrN), .confDoneOvrN(confDoneOvrN), .dataEn(dataEn),
    .clkEn(clkEn), .errCode(errCode)
  );

  // R7
  stream_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> (!nCe && nConfig && !cfgOvrN && !nConfigOvrN && nStatusOvrN && confDoneOvrN));

  // R5
  ncfg_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nConfig |-> (!nConfigOvrN && !nCe));

  // R10
  done_rel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (nCe && cfgOvrN && nConfigOvrN && !dataEn && errCode == 4'd0));

  // R11
  err_rel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done && errCode != 4'd0) |-> (nCe && nConfig && cfgOvrN && nConfigOvrN && !dataEn && !clkEn));

endmodule

// File: tb/test_cfgseq_top.sv
module test_cfgseq_top;

  localparam int TW = 16;
  localparam int MW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [TW-1:0] timeoutLimit = 16'd20;
  logic [MW-1:0] modeSel = '0;
  logic          pinNConfig = 1'b0, pinNStatus = 1'b0, pinConfDone = 1'b0;
  logic          pinConfDoneOe = 1'b1, pinUserMode = 1'b0, streamEnd = 1'b0;
  logic          nCe, nConfig, prRequest, nStatusOe, confDoneOe;
  logic          cfgOvrN, nConfigOvrN, nStatusOvrN, confDoneOvrN;
  logic          dataEn, clkEn, busy, done;
  logic [3:0]    errCode;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  cfgseq_top #(.TW(TW), .MW(MW)) i_cfgseq_top (
    .clk(clk), .rstN(rstN), .start(start), .timeoutLimit(timeoutLimit),
    .modeSel(modeSel), .pinNConfig(pinNConfig), .pinNStatus(pinNStatus),
    .pinConfDone(pinConfDone), .pinConfDoneOe(pinConfDoneOe),
    .pinUserMode(pinUserMode), .streamEnd(streamEnd),
    .nCe(nCe), .nConfig(nConfig), .prRequest(prRequest), .nStatusOe(nStatusOe),
    .confDoneOe(confDoneOe), .cfgOvrN(cfgOvrN), .nConfigOvrN(nConfigOvrN),
    .nStatusOvrN(nStatusOvrN), .confDoneOvrN(confDoneOvrN), .dataEn(dataEn),
    .clkEn(clkEn), .busy(busy), .done(done), .errCode(errCode)
  );

  // Pin model state
  int fault, variant, holdCnt, d1, d2, d3, d4;
  int hiCnt, dataCnt, cdCnt, umCnt;
  bit seenLow, nsHigh, sEndGiven, cdUp, umUp, nsDrop, cdDrop, cfgHeld;
  bit restart, rsDone, sawStream, sawLow;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCode(input int f, input int mode);
    if ((mode >> 1) != 0) return 1;
    return f;
  endfunction

  task automatic driveModel();
    pinNConfig    = (holdCnt > 0) || (fault == 2) || cfgHeld;
    pinNStatus    = ((holdCnt > 0) || nsHigh || (fault == 4 && seenLow)) && !nsDrop;
    pinConfDone   = (cdUp || (fault == 6 && variant == 0)) && !cdDrop;
    pinConfDoneOe = !(fault == 6 && variant == 1);
    pinUserMode   = umUp;
  endtask

  task automatic setupModel(input int f, input int lim);
    fault = f; variant = $urandom_range(0, 1);
    timeoutLimit = TW'(lim);
    holdCnt = $urandom_range(0, lim / 2);
    d1 = $urandom_range(0, lim / 2); d2 = $urandom_range(0, lim / 2);
    d3 = $urandom_range(0, lim / 2); d4 = $urandom_range(0, lim / 2);
    hiCnt = 0; dataCnt = 0; cdCnt = 0; umCnt = 0;
    seenLow = 0; nsHigh = 0; sEndGiven = 0; cdUp = 0; umUp = 0;
    nsDrop = 0; cdDrop = 0; cfgHeld = 0; rsDone = 0; sawStream = 0; sawLow = 0;
    streamEnd = 0;
    driveModel();
  endtask

  task automatic tick();
    @(negedge clk);
    start = 1'b0;
    if (dataEn && !sawStream) begin
      sawStream = 1;
      // R7
      check(!nCe && nConfig && !cfgOvrN && !nConfigOvrN && nStatusOvrN && confDoneOvrN && clkEn,
            "R7 stream drive", {nCe, nConfig, cfgOvrN, nConfigOvrN, nStatusOvrN, confDoneOvrN, clkEn}, 7'b0100111);
    end
    if (!nConfig && !sawLow) begin
      sawLow = 1;
      // R5 R4
      check(!nCe && !nConfigOvrN && !cfgOvrN, "R5 pulse under override", {nCe, nConfigOvrN, cfgOvrN}, 0);
    end
    if (holdCnt > 0) holdCnt--;
    if (fault == 3 && !nCe) cfgHeld = 1;
    if (!nConfig && !nConfigOvrN) seenLow = 1;
    if (seenLow && nConfig && !nsHigh && fault != 5) begin
      if (hiCnt >= d1) nsHigh = 1; else hiCnt++;
    end
    if (streamEnd) begin
      streamEnd = 0; sEndGiven = 1;
      if (fault == 9) nsDrop = 1;
    end else if (dataEn && fault != 7 && !sEndGiven) begin
      if (dataCnt >= d2) streamEnd = 1; else dataCnt++;
      if (restart && !rsDone) begin start = 1'b1; rsDone = 1; end
    end
    if (sEndGiven && !cdUp && fault != 8 && fault != 9) begin
      if (cdCnt >= d3) cdUp = 1; else cdCnt++;
    end
    if (cdUp && !umUp && fault != 10) begin
      if (umCnt >= d4) umUp = 1; else umCnt++;
    end
    if (fault == 11 && umUp && nCe) cdDrop = 1;
    driveModel();
  endtask

  task automatic runSeq(input int f, input int mode, input int lim, input bit rs);
    int exp;
    setupModel(f, lim);
    modeSel = MW'(mode);
    restart = rs;
    @(negedge clk);
    start = 1'b1;
    tick();
    for (int k = 0; k < 3000 && busy; k++) tick();
    exp = expCode(f, mode);
    // R2 R3 R4 R5 R6 R7 R8 R9 R10 R12
    check(errCode == 4'(exp), $sformatf("R%0s code fault=%0d", (exp == 0) ? "10" : "11", f), errCode, exp);
    check(done == (exp == 0) && !busy, "R10 done flag", done, exp == 0);
    // R9 R11
    check(nCe && nConfig && cfgOvrN && nConfigOvrN && !dataEn && !clkEn,
          "R11 released outputs", {nCe, nConfig, cfgOvrN, nConfigOvrN, dataEn, clkEn}, 6'b111100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    fault = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(nCe && nConfig && !prRequest && !nStatusOe && !confDoneOe && cfgOvrN && nConfigOvrN &&
          nStatusOvrN && confDoneOvrN && !dataEn && !clkEn && !busy && !done && errCode == 0,
          "R1 reset state", {nCe, nConfig, cfgOvrN, nConfigOvrN, dataEn, busy, done}, 7'b1111000);

    // R3 exact timeout instant on the first release wait
    setupModel(2, 10);
    modeSel = '0; restart = 0;
    start = 1'b1;
    for (int k = 1; k <= 13; k++) begin
      tick();
      if (k == 12) check(errCode == 0, "R3 before timeout", errCode, 0);
      if (k == 13) check(errCode == 2, "R3 timeout edge", errCode, 2);
    end

    // R2 directed mode values
    runSeq(0, 0, 20, 0);
    runSeq(0, 1, 20, 0);
    runSeq(1, 2, 20, 0);
    runSeq(1, 4, 20, 0);
    // R12 start during streaming is ignored
    runSeq(0, 1, 24, 1);
    // R4 R6 R8 directed faults
    runSeq(3, 0, 16, 0);
    runSeq(6, 0, 16, 0);
    runSeq(9, 1, 16, 0);
    runSeq(11, 0, 16, 0);

    for (int n = 0; n < 60; n++) begin
      int f, m;
      f = $urandom_range(0, 11);
      if ($urandom_range(0, 3) == 0) f = 0;
      m = (f == 1) ? $urandom_range(2, 7) : $urandom_range(0, 1);
      runSeq(f, m, $urandom_range(8, 40), ($urandom_range(0, 4) == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule